// File: doc/BRIEF.md
# Banked Word-Address Mapper

This block sits between a 16-bit CPU and its storage. The CPU reaches 64K words directly, and the physical store holds 256K words. The CPU address space is divided into four windows of 16K words. Each window has its own bank register, which points that window at one of sixteen physical 16K-word banks. The eight lower physical banks are read-only memory and the eight upper banks are RAM. The mapper produces the 18-bit physical word address and a chip select for each kind of storage.

The top 256 words of the CPU space form a fixed I/O page. This page always overrides the bank mapping. Any access to it selects the peripheral bus and holds the CPU for one extra cycle, which gives the slow byte-wide devices time to respond. The stack grows upward, so a stack overrun eventually runs into this page. When a stack access lands in the I/O page, the mapper raises a non-maskable interrupt. The interrupt is a one-cycle pulse, and it is held pending until the CPU acknowledges it.

Bank registers are loaded through a small write port that carries a window index and a bank number.

Top module: `bkmap_top`

## Requirements
- R1: After reset, window n (CPU address bits [15:14] = n) maps to physical bank n. Windows 0 to 3 therefore all start in read-only memory, with address 0 in bank 0.
- R2: For any CPU address outside the I/O page, `phys_addr` equals {bank register of window addr[15:14], addr[13:0]}.
- R3: When `bank_we` is high at a clock edge, the bank register selected by `bank_sel` loads `bank_val`. The new mapping applies from the following cycle.
- R4: A read (`rd_en`) through a window whose bank value is 0 to 7 (bank bit 3 = 0) asserts `rom_cs`, and no other select.
- R5: A read or write through a window whose bank value is 8 to 15 (bank bit 3 = 1) asserts `ram_cs`. `ram_we` is high exactly when such an access is a write.
- R6: A write through a window that maps to a read-only bank has no effect: `rom_cs`, `ram_cs` and `ram_we` all stay low.
- R7: Any read or write to CPU addresses 0xFF00 to 0xFFFF asserts `io_cs` and never `rom_cs`, `ram_cs` or `ram_we`, whatever the bank registers hold.
- R8: `ready` is low in the first cycle of an I/O page access and high in the second cycle. A CPU that holds the access for two cycles completes it. Memory accesses and idle cycles keep `ready` high.
- R9: A stack access (`stk_acc` high with a read or write) to the I/O page causes `nmi` to be high for exactly one cycle, in the cycle after the offending access. A stack access below the I/O page, or an I/O access without `stk_acc`, raises nothing.
- R10: After a pulse, the interrupt stays pending until `nmi_ack` is high at a clock edge. Further offences while it is pending give no pulse. An offence in the same cycle as the acknowledge keeps it pending without a pulse. An offence after the acknowledge pulses again.
- R11: With `rd_en` and `wr_en` both low, no chip select is asserted and `ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU word address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| stk_acc | input | 1 | Current access is a stack access |
| bank_we | input | 1 | Load a bank register |
| bank_sel | input | 2 | Window whose bank register is loaded |
| bank_val | input | 4 | Physical bank number to load |
| nmi_ack | input | 1 | CPU acknowledges the pending interrupt |
| phys_addr | output | 18 | Physical word address |
| rom_cs | output | 1 | Read-only memory select |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| io_cs | output | 1 | I/O page select |
| ready | output | 1 | Low while the access must be extended |
| nmi | output | 1 | Non-maskable interrupt pulse |

## Verification
A bank register holding the wrong value shows up on the very next access through its window. The four high bits of `phys_addr` are wrong, and if the value crosses bank 8, the read-only and RAM selects swap. A stuck wait flag makes `ready` wrong in the first or second cycle of an I/O access. A pending flag that is lost or stuck shows at the next stack overrun, as an extra pulse or a missing one. The bench's model follows each of these states and compares every output on every clock, so each fault is seen in the cycle where it first affects the ports.

// File: rtl/bkmap_pkg.sv
package bkmap_pkg;
  localparam int unsigned CPU_AW  = 16;
  localparam int unsigned WIN_BW  = 2;
  localparam int unsigned BANK_BW = 4;
  localparam int unsigned IOPG_BW = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ROM  = 2'd1,
    SEL_RAM  = 2'd2,
    SEL_IO   = 2'd3
  } target_e;
endpackage

// File: rtl/bkmap_bank_regs.sv
module bkmap_bank_regs #(
  parameter int unsigned WIN_W  = 2,
  parameter int unsigned BANK_W = 4,
  parameter int unsigned NWIN   = 1 << WIN_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [WIN_W-1:0]         load_win,
  input  logic [BANK_W-1:0]        load_val,
  output logic [NWIN*BANK_W-1:0]   banks_flat
);
  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic              ld_en;
    logic [BANK_W-1:0] bank_d;
    logic [BANK_W-1:0] bank_q;

    always_comb begin
      ld_en  = load && (load_win == WIN_W'(g));
      bank_d = load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q <= BANK_W'(g);
      end else if (ld_en) begin
        bank_q <= bank_d;
      end
    end

    assign banks_flat[g*BANK_W +: BANK_W] = bank_q;
  end
endmodule

// File: rtl/bkmap_decode.sv
module bkmap_decode
  import bkmap_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WIN_W  = 2,
  parameter int unsigned BANK_W = 4,
  parameter int unsigned IO_W   = 8,
  parameter int unsigned NWIN   = 1 << WIN_W,
  parameter int unsigned OFF_W  = ADDR_W - WIN_W,
  parameter int unsigned PHYS_W = BANK_W + OFF_W
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [NWIN*BANK_W-1:0]  banks_flat,
  output logic [PHYS_W-1:0]       phys_addr,
  output logic                    rom_cs,
  output logic                    ram_cs,
  output logic                    ram_we,
  output logic                    io_acc
);
  logic [WIN_W-1:0]  win;
  logic [BANK_W-1:0] bank;
  logic              io_page;
  logic              any_acc;
  logic              bank_is_ram;
  target_e           tgt;

  always_comb begin
    win  = addr[ADDR_W-1 -: WIN_W];
    bank = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (win == WIN_W'(i)) begin
        bank = banks_flat[i*BANK_W +: BANK_W];
      end
    end
  end

  always_comb begin
    io_page     = &addr[ADDR_W-1 -: IO_W];
    any_acc     = rd_en | wr_en;
    bank_is_ram = bank[BANK_W-1];
    phys_addr   = {bank, addr[OFF_W-1:0]};

    tgt = SEL_NONE;
    if (any_acc) begin
      if (io_page) begin
        tgt = SEL_IO;
      end else if (bank_is_ram) begin
        tgt = SEL_RAM;
      end else if (rd_en) begin
        tgt = SEL_ROM;
      end
    end

    rom_cs = (tgt == SEL_ROM);
    ram_cs = (tgt == SEL_RAM);
    ram_we = (tgt == SEL_RAM) && wr_en;
    io_acc = (tgt == SEL_IO);
  end
endmodule

// File: rtl/bkmap_iowait.sv
module bkmap_iowait (
  input  logic clk,
  input  logic rst_n,
  input  logic io_acc,
  output logic ready
);
  logic held_q;
  logic held_d;
  logic held_en;

  always_comb begin
    held_en = io_acc | held_q;
    held_d  = io_acc & ~held_q;
    ready   = ~io_acc | held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end
endmodule

// File: rtl/bkmap_nmi.sv
module bkmap_nmi (
  input  logic clk,
  input  logic rst_n,
  input  logic stk_acc,
  input  logic io_acc,
  input  logic ack,
  output logic nmi
);
  logic offence;
  logic pend_q, pend_d;
  logic pulse_q, pulse_d;

  always_comb begin
    offence = stk_acc & io_acc;
    pend_d  = (pend_q & ~ack) | offence;
    pulse_d = offence & ~pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      pulse_q <= pulse_d;
    end
  end

  assign nmi = pulse_q;
endmodule

// File: rtl/bkmap_top.sv
module bkmap_top
  import bkmap_pkg::*;
#(
  parameter int unsigned ADDR_W = CPU_AW,
  parameter int unsigned WIN_W  = WIN_BW,
  parameter int unsigned BANK_W = BANK_BW,
  parameter int unsigned IO_W   = IOPG_BW
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 cpu_addr,
  input  logic                              rd_en,
  input  logic                              wr_en,
  input  logic                              stk_acc,
  input  logic                              bank_we,
  input  logic [WIN_W-1:0]                  bank_sel,
  input  logic [BANK_W-1:0]                 bank_val,
  input  logic                              nmi_ack,
  output logic [BANK_W+ADDR_W-WIN_W-1:0]    phys_addr,
  output logic                              rom_cs,
  output logic                              ram_cs,
  output logic                              ram_we,
  output logic                              io_cs,
  output logic                              ready,
  output logic                              nmi
);
  localparam int unsigned NWIN   = 1 << WIN_W;
  localparam int unsigned OFF_W  = ADDR_W - WIN_W;
  localparam int unsigned PHYS_W = BANK_W + OFF_W;

  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NWIN*BANK_W-1:0] banks_flat;
  logic                   io_acc;

  bkmap_bank_regs #(.WIN_W(WIN_W), .BANK_W(BANK_W), .NWIN(NWIN)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (bank_we),
    .load_win   (bank_sel),
    .load_val   (bank_val),
    .banks_flat (banks_flat)
  );

  bkmap_decode #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .BANK_W(BANK_W), .IO_W(IO_W),
    .NWIN(NWIN), .OFF_W(OFF_W), .PHYS_W(PHYS_W)
  ) u_dec (
    .addr       (cpu_addr),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .banks_flat (banks_flat),
    .phys_addr  (phys_addr),
    .rom_cs     (rom_cs),
    .ram_cs     (ram_cs),
    .ram_we     (ram_we),
    .io_acc     (io_acc)
  );

  bkmap_iowait u_wait (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .io_acc (io_acc),
    .ready  (ready)
  );

  bkmap_nmi u_nmi (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .stk_acc (stk_acc),
    .io_acc  (io_acc),
    .ack     (nmi_ack),
    .nmi     (nmi)
  );

  assign io_cs = io_acc;
endmodule

// File: rtl/bkmap_chk.sv
module bkmap_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_en,
  input logic wr_en,
  input logic stk_acc,
  input logic rom_cs,
  input logic ram_cs,
  input logic ram_we,
  input logic io_cs,
  input logic ready,
  input logic nmi
);
  assert_io_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    io_cs |-> (!rom_cs && !ram_cs && !ram_we));

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs, io_cs}));

  assert_rom_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en) |-> !rom_cs);

  assert_ram_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_cs && wr_en));

  assert_wait_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_cs) |-> !ready);

  assert_nmi_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !nmi);

  assert_nmi_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> $past(stk_acc && io_cs));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |-> (!rom_cs && !ram_cs && !io_cs && ready));
endmodule

bind bkmap_top bkmap_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .stk_acc (stk_acc),
  .rom_cs  (rom_cs),
  .ram_cs  (ram_cs),
  .ram_we  (ram_we),
  .io_cs   (io_cs),
  .ready   (ready),
  .nmi     (nmi)
);

// File: tb/bkmap_top_tb_top.sv
module bkmap_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        rd_en, wr_en, stk_acc, bank_we, nmi_ack;
  logic [1:0]  bank_sel;
  logic [3:0]  bank_val;
  logic [17:0] phys_addr;
  logic        rom_cs, ram_cs, ram_we, io_cs, ready, nmi;

  always #10 clk = ~clk;

  bkmap_top dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .rd_en(rd_en), .wr_en(wr_en),
    .stk_acc(stk_acc), .bank_we(bank_we), .bank_sel(bank_sel), .bank_val(bank_val),
    .nmi_ack(nmi_ack), .phys_addr(phys_addr), .rom_cs(rom_cs), .ram_cs(ram_cs),
    .ram_we(ram_we), .io_cs(io_cs), .ready(ready), .nmi(nmi)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  int  m_bank[4];
  bit  m_wait, m_pend, m_nmi;

  task automatic chk(input int act, input int exp, input string what, input string tag);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s (%s): got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input bit r, input bit w, input bit s,
                      input bit bw, input int bs, input int bv, input bit ack,
                      input string tag);
    int b, e_phys;
    bit io, acc, e_rom, e_ram, e_we, e_io, e_rdy;
    bit n_wait, n_pend, n_nmi;
    @(negedge clk);
    cpu_addr = a; rd_en = r; wr_en = w; stk_acc = s;
    bank_we = bw; bank_sel = 2'(bs); bank_val = 4'(bv); nmi_ack = ack;
    #2;
    acc    = r | w;
    io     = (a[15:8] == 8'hFF);
    b      = m_bank[a[15:14]];
    e_phys = b * 16384 + int'(a[13:0]);
    e_rom  = r && !io && b < 8;
    e_ram  = acc && !io && b >= 8;
    e_we   = w && e_ram;
    e_io   = acc && io;
    e_rdy  = !e_io || m_wait;
    if (!e_io) chk(int'(phys_addr), e_phys, "phys_addr R2", tag);
    chk(int'(rom_cs), int'(e_rom), "rom_cs R4", tag);
    chk(int'(ram_cs), int'(e_ram), "ram_cs R5", tag);
    chk(int'(ram_we), int'(e_we), "ram_we R5", tag);
    chk(int'(io_cs), int'(e_io), "io_cs R7", tag);
    chk(int'(ready), int'(e_rdy), "ready R8", tag);
    chk(int'(nmi), int'(m_nmi), "nmi R9", tag);
    @(posedge clk);
    n_wait = e_io && !m_wait;
    n_nmi  = s && e_io && !m_pend;
    n_pend = (m_pend && !ack) || (s && e_io);
    m_wait = n_wait; m_nmi = n_nmi; m_pend = n_pend;
    if (bw) m_bank[bs] = bv;
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    step(a, 1, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input logic [15:0] a, input string tag);
    step(a, 0, 1, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic srd(input logic [15:0] a, input string tag);
    step(a, 1, 0, 1, 0, 0, 0, 0, tag);
  endtask
  task automatic setbank(input int win, input int val, input string tag);
    step(16'h0000, 0, 0, 0, 1, win, val, 0, tag);
  endtask
  task automatic idle(input string tag);
    step(16'h1234, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic ack1(input string tag);
    step(16'h0000, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_bank[i] = i;
    m_wait = 0; m_pend = 0; m_nmi = 0;
    rst_n = 1'b0; cpu_addr = '0; rd_en = 0; wr_en = 0; stk_acc = 0;
    bank_we = 0; bank_sel = '0; bank_val = '0; nmi_ack = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset mapping: each window reads from its own bank in ROM
    rd(16'h0000, "R1 win0");
    rd(16'h4000, "R1 win1");
    rd(16'h8001, "R1 win2");
    rd(16'hC123, "R1 win3");
    rd(16'h3FFF, "R1 win0 top");
    // R11 idle
    idle("R11 idle");
    // R3 bank loads, R5 RAM
    setbank(1, 9, "R3 load win1");
    rd(16'h4123, "R3 win1 now RAM");
    wr(16'h4ABC, "R5 RAM write");
    setbank(2, 15, "R3 load win2");
    wr(16'h8ABC, "R5 bank15 write");
    rd(16'hBFFF, "R2 bank15 top");
    setbank(2, 7, "R3 load win2 rom");
    rd(16'h8010, "R4 bank7 read");
    // R6 write to ROM ignored
    wr(16'h0010, "R6 rom write");
    wr(16'h8010, "R6 rom write bank7");
    // R7/R8 I/O page with wait
    rd(16'hFF00, "R8 io first");
    rd(16'hFF00, "R8 io second");
    wr(16'hFFFF, "R7 io write first");
    wr(16'hFFFF, "R7 io write second");
    rd(16'hFEFF, "R7 just below page");
    setbank(3, 12, "R3 win3 to RAM");
    wr(16'hFF80, "R7 io over RAM");
    wr(16'hFF80, "R7 io over RAM 2");
    wr(16'hFEFF, "R5 below page RAM");
    // R9 NMI
    srd(16'hFEFE, "R9 stack below page");
    rd(16'hFF10, "R9 io without stack");
    rd(16'hFF10, "R9 io without stack 2");
    srd(16'hFF10, "R9 stack overrun");
    srd(16'hFF10, "R9 pulse cycle");
    idle("R9 pulse over");
    // R10 pending suppresses
    srd(16'hFF20, "R10 repeat pending");
    srd(16'hFF20, "R10 repeat pending 2");
    idle("R10 no second pulse");
    step(16'hFF30, 1, 0, 1, 0, 0, 0, 1, "R10 offence with ack");
    idle("R10 still pending");
    ack1("R10 ack");
    srd(16'hFF40, "R10 after ack");
    srd(16'hFF40, "R10 pulse again");
    ack1("R10 clear");
    // mixed stimulus
    for (int k = 0; k < 400; k++) begin
      logic [31:0] rv;
      logic [15:0] a;
      rv = $urandom;
      a  = rv[3] ? {8'hFF, rv[31:24]} : rv[31:16];
      step(a, rv[0], rv[1] & ~rv[0], rv[2], rv[4] & rv[5], int'(rv[7:6]),
           int'(rv[11:8]), rv[12] & rv[13], "R2 mixed");
    end
    idle("R11 final");
    done = 1;
    summary();
    $finish;
  end
endmodule